// File: doc/BRIEF.md
# Delta-Pixel Panel Drive Timing Generator

This block turns a dot-rate clock plus line and frame sync pulses into the digital drive waveforms for a small active-matrix LCD panel. The panel has its own shift-register row and column drivers. The block produces the following outputs:

- a horizontal start pulse;
- a complementary pair of horizontal shift clocks;
- a vertical start pulse;
- a complementary pair of vertical shift clocks;
- a gate enable;
- a clear pulse that reduces shading;
- a registered scan-direction level;
- a video polarity flag that flips on every line.

The panel's colour dots sit in a delta layout, so each row is offset by one and a half dots from its neighbour. The block therefore delays the horizontal start by half a horizontal clock period on every other line. Red, green and blue are sampled together, so one line needs only `H_PULSES` horizontal clock periods.

The block keeps two counters:

- A dot-clock counter restarts at every line start and saturates once the line's activity is over. All horizontal edges are decoded from it.
- A line counter restarts on frame sync and saturates after the scan. The vertical pulses and the gate enable are decoded from it together with a fixed column, `V_EDGE`.

In PAL mode the gate enable is withheld for one line out of every `SKIP_PERIOD`, so that the fixed visible row count covers a taller field. All outputs are registered. Every control pin is a plain level or a single-cycle pulse, and no pin carries a data stream, so there is no handshake and no back-pressure.

Top module: `delta_panel_timing`

## Requirements
- R1: While `rst_n` is low, both horizontal clocks, both vertical clocks, `h_start`, `v_start`, `clr_pulse` and `vid_invert` are 0, and `gate_en` and `scan_ltr` are 1.
- R2: Call the clock edge that samples `line_sync` (or `frame_sync`) high position 0. `h_start` is high for `2*HALF` cycles, covering positions S to S+2*HALF-1, where S = `H_LEAD` on even lines and `H_LEAD+HALF` on odd lines. Outputs appear one cycle after the position they decode.
- R3: Starting at position S+HALF, `h_clk_a` is high for `HALF` cycles and then low for `HALF` cycles, repeated for exactly `H_PULSES` periods. `h_clk_b` is the exact complement during that burst. Both clocks are 0 outside the burst, so `h_clk_a` rises only after `h_start` has been stable for `HALF` cycles.
- R4: The half-period delay of R2 and R3 applies when the line parity is odd. The parity is 1 on the first line after reset and alternates on every line start.
- R5: With `USE_CLR`=1, `clr_pulse` is high for `CLR_W` cycles, covering positions S-CLR_GAP-CLR_W to S-CLR_GAP-1, so it always ends before `h_start` rises. With `USE_CLR`=0 it stays 0.
- R6: A frame start is a line start that also resets the line index to 0. `v_start` is high for the whole of line 0.
- R7: Let the scan index be the line index from position `V_EDGE` of that line up to position `V_EDGE-1` of the next line. `v_clk_b` is high while the scan index is even and `v_clk_a` while it is odd. This holds only for scan indices 0 to `V_LINES-1`; otherwise both are 0. The first edge is therefore a `v_clk_b` rise in line 0, while `v_start` is high.
- R8: `gate_en` is 1 whenever `pal_mode` is 0. When `pal_mode` is 1, `gate_en` is 0 while an index that switches at position `V_EDGE+EN_LAG` is in range 0 to `V_LINES-1` and equals `SKIP_PHASE` modulo `SKIP_PERIOD`. It falls after a `v_clk_b` rise and rises after the following `v_clk_a` rise.
- R9: `vid_invert` shows the line parity of R4. It changes on the line-start edge itself.
- R10: `scan_ltr` equals `dir_ltr` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_sync | input | 1 | One-cycle pulse at the start of each line |
| frame_sync | input | 1 | One-cycle pulse marking a line that is also the frame start |
| dir_ltr | input | 1 | 1 = scan left to right, 0 = right to left |
| pal_mode | input | 1 | 1 = PAL line skipping through the gate enable |
| h_start | output | 1 | Horizontal shift-register start pulse |
| h_clk_a | output | 1 | Horizontal clock, phase sampling the start |
| h_clk_b | output | 1 | Horizontal clock, complementary phase |
| v_start | output | 1 | Vertical shift-register start pulse |
| v_clk_a | output | 1 | Vertical clock, odd rows |
| v_clk_b | output | 1 | Vertical clock, even rows, samples the start |
| gate_en | output | 1 | Gate-select enable |
| clr_pulse | output | 1 | Shading-reduction clear pulse |
| scan_ltr | output | 1 | Registered scan direction |
| vid_invert | output | 1 | Video polarity for the current line |

## Verification
The bench runs a reduced configuration over whole frames and compares every output on every cycle with a position-by-position model.

It checks these corner cases:
- The odd-line shift. A design that ignores parity, or shifts the wrong lines, places `h_start` and the clock burst three cycles off.
- The last burst period and the pulse count. An off-by-one adds or drops a horizontal clock.
- The `V_EDGE` boundary, where a line start must not yet move the vertical clocks. It also covers the first and last scan rows.
- The PAL skip window, both its position and its lag, and that it stays disabled in NTSC mode.
- A second instance built without the clear pulse, which must hold it low.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  typedef struct packed {
    logic start;
    logic clk_a;
    logic clk_b;
    logic clr;
  } hdrive_t;

  typedef struct packed {
    logic start;
    logic clk_a;
    logic clk_b;
    logic en;
  } vdrive_t;

  localparam hdrive_t HDRIVE_IDLE = '{start: 1'b0, clk_a: 1'b0, clk_b: 1'b0, clr: 1'b0};
  localparam vdrive_t VDRIVE_IDLE = '{start: 1'b0, clk_a: 1'b0, clk_b: 1'b0, en: 1'b1};

endpackage

// File: rtl/dtg_hpath.sv
module dtg_hpath
  import dtg_pkg::*;
#(
  parameter int HALF     = 3,
  parameter int H_PULSES = 174,
  parameter int H_LEAD   = 12,
  parameter int CLR_W    = 3,
  parameter int CLR_GAP  = 2,
  parameter bit USE_CLR  = 1'b1,
  parameter int HW       = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  output logic [HW-1:0] hpos,
  output logic          parity,
  output hdrive_t       hdrv
);

  localparam logic [HW-1:0] K_LEAD = HW'(H_LEAD);
  localparam logic [HW-1:0] K_HALF = HW'(HALF);
  localparam logic [HW-1:0] K_PER  = HW'(2 * HALF);
  localparam logic [HW-1:0] K_BLEN = HW'(2 * HALF * H_PULSES);
  localparam logic [HW-1:0] K_CLRW = HW'(CLR_W);
  localparam logic [HW-1:0] K_CLRG = HW'(CLR_GAP);
  localparam logic [HW-1:0] K_MAX  = '1;

  logic [HW-1:0] st_pos, burst_pos, burst_off, clr_pos;
  logic          in_start, in_burst, hi_phase, in_clr;
  hdrive_t       nxt;

  // dot counter and line parity
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hpos   <= K_MAX;
      parity <= 1'b0;
    end else if (line_start) begin
      hpos   <= '0;
      parity <= ~parity;
    end else if (hpos != K_MAX) begin
      hpos   <= hpos + 1'b1;
    end
  end

  always_comb begin
    st_pos    = K_LEAD + (parity ? K_HALF : '0);
    burst_pos = st_pos + K_HALF;
    burst_off = hpos - burst_pos;
    clr_pos   = st_pos - K_CLRG - K_CLRW;
    in_start  = (hpos >= st_pos) && (hpos < st_pos + K_PER);
    in_burst  = (hpos >= burst_pos) && (hpos < burst_pos + K_BLEN);
    hi_phase  = (burst_off % K_PER) < K_HALF;
    in_clr    = (hpos >= clr_pos) && (hpos < st_pos - K_CLRG);
  end

  generate
    if (USE_CLR) begin : g_clr
      always_comb nxt.clr = in_clr;
    end else begin : g_noclr
      always_comb nxt.clr = 1'b0;
    end
  endgenerate

  always_comb begin
    nxt.start = in_start;
    nxt.clk_a = in_burst && hi_phase;
    nxt.clk_b = in_burst && !hi_phase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hdrv <= HDRIVE_IDLE;
    else        hdrv <= nxt;
  end

  assert_clr_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hdrv.clr |-> !hdrv.start);
  assert_start_quiet_clocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdrv.start) |-> (!hdrv.clk_a && !hdrv.clk_b));
  assert_parity_flips_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(line_start) |-> (parity != $past(parity)));

endmodule

// File: rtl/dtg_vpath.sv
module dtg_vpath
  import dtg_pkg::*;
#(
  parameter int V_LINES     = 218,
  parameter int V_EDGE      = 6,
  parameter int EN_LAG      = 2,
  parameter int SKIP_PERIOD = 6,
  parameter int SKIP_PHASE  = 4,
  parameter int HW          = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          frame_start,
  input  logic          pal_mode,
  input  logic [HW-1:0] hpos,
  output vdrive_t       vdrv
);

  localparam int VW = $clog2(V_LINES + 2) + 1;
  localparam int MW = $clog2(SKIP_PERIOD + 1);
  localparam logic [VW-1:0] K_VL   = VW'(V_LINES);
  localparam logic [VW-1:0] K_VMAX = '1;
  localparam logic [HW-1:0] K_VE   = HW'(V_EDGE);
  localparam logic [HW-1:0] K_EE   = HW'(V_EDGE + EN_LAG);
  localparam logic [MW-1:0] K_MTOP = MW'(SKIP_PERIOD - 1);
  localparam logic [MW-1:0] K_MPH  = MW'(SKIP_PHASE);

  logic [VW-1:0] vline;
  logic [MW-1:0] vmod, mod_e;
  logic          late_v, act_v, odd_v, late_e, act_e, skip;
  vdrive_t       nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vline <= K_VMAX;
      vmod  <= '0;
    end else if (frame_start) begin
      vline <= '0;
      vmod  <= '0;
    end else if (line_start) begin
      if (vline != K_VMAX) vline <= vline + 1'b1;
      vmod <= (vmod == K_MTOP) ? '0 : vmod + 1'b1;
    end
  end

  always_comb begin
    late_v = hpos >= K_VE;
    act_v  = late_v ? (vline < K_VL) : ((vline != '0) && (vline <= K_VL));
    odd_v  = late_v ? vline[0] : ~vline[0];
    late_e = hpos >= K_EE;
    act_e  = late_e ? (vline < K_VL) : ((vline != '0) && (vline <= K_VL));
    mod_e  = late_e ? vmod : ((vmod == '0) ? K_MTOP : vmod - 1'b1);
    skip   = pal_mode && act_e && (mod_e == K_MPH);
    nxt.start = (vline == '0);
    nxt.clk_a = act_v && odd_v;
    nxt.clk_b = act_v && !odd_v;
    nxt.en    = !skip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vdrv <= VDRIVE_IDLE;
    else        vdrv <= nxt;
  end

  assert_ntsc_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pal_mode) |-> vdrv.en);
  assert_vstart_before_scan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vdrv.start) |-> (!vdrv.clk_a && !vdrv.clk_b));
  assert_vclk_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vdrv.clk_b) |-> !vdrv.clk_a);

endmodule

// File: rtl/delta_panel_timing.sv
module delta_panel_timing
  import dtg_pkg::*;
#(
  parameter int HALF        = 3,
  parameter int H_PULSES    = 174,
  parameter int H_LEAD      = 12,
  parameter int CLR_W       = 3,
  parameter int CLR_GAP     = 2,
  parameter bit USE_CLR     = 1'b1,
  parameter int V_LINES     = 218,
  parameter int V_EDGE      = 6,
  parameter int EN_LAG      = 2,
  parameter int SKIP_PERIOD = 6,
  parameter int SKIP_PHASE  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_sync,
  input  logic frame_sync,
  input  logic dir_ltr,
  input  logic pal_mode,
  output logic h_start,
  output logic h_clk_a,
  output logic h_clk_b,
  output logic v_start,
  output logic v_clk_a,
  output logic v_clk_b,
  output logic gate_en,
  output logic clr_pulse,
  output logic scan_ltr,
  output logic vid_invert
);

  localparam int H_END = H_LEAD + 2 * HALF + 2 * HALF * H_PULSES;
  localparam int HW    = $clog2(H_END + V_EDGE + EN_LAG + 2) + 1;

  logic          line_start;
  logic [HW-1:0] hpos;
  hdrive_t       hdrv;
  vdrive_t       vdrv;

  assign line_start = line_sync || frame_sync;

  dtg_hpath #(
    .HALF(HALF), .H_PULSES(H_PULSES), .H_LEAD(H_LEAD),
    .CLR_W(CLR_W), .CLR_GAP(CLR_GAP), .USE_CLR(USE_CLR), .HW(HW)
  ) u_hpath (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .hpos(hpos), .parity(vid_invert), .hdrv(hdrv)
  );

  dtg_vpath #(
    .V_LINES(V_LINES), .V_EDGE(V_EDGE), .EN_LAG(EN_LAG),
    .SKIP_PERIOD(SKIP_PERIOD), .SKIP_PHASE(SKIP_PHASE), .HW(HW)
  ) u_vpath (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .frame_start(frame_sync), .pal_mode(pal_mode), .hpos(hpos), .vdrv(vdrv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scan_ltr <= 1'b1;
    else        scan_ltr <= dir_ltr;
  end

  assign h_start   = hdrv.start;
  assign h_clk_a   = hdrv.clk_a;
  assign h_clk_b   = hdrv.clk_b;
  assign clr_pulse = hdrv.clr;
  assign v_start   = vdrv.start;
  assign v_clk_a   = vdrv.clk_a;
  assign v_clk_b   = vdrv.clk_b;
  assign gate_en   = vdrv.en;

  assert_dir_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (scan_ltr == $past(dir_ltr)));

endmodule

// File: tb/test_delta_panel_timing.sv
module test_delta_panel_timing;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3, NP = 4, LEAD = 8, CW = 2, CG = 1;
  localparam int VL = 14, VE = 4, EL = 2, SP = 6, SPH = 4;
  localparam int LINE_LEN = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic line_sync = 1'b0, frame_sync = 1'b0, dir_ltr = 1'b1, pal_mode = 1'b0;
  logic h_start, h_clk_a, h_clk_b, v_start, v_clk_a, v_clk_b;
  logic gate_en, clr_pulse, scan_ltr, vid_invert;
  logic n_hs, n_ha, n_hb, n_vs, n_va, n_vb, n_en, n_clr, n_dir, n_inv;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  delta_panel_timing #(.HALF(HALF), .H_PULSES(NP), .H_LEAD(LEAD), .CLR_W(CW),
    .CLR_GAP(CG), .USE_CLR(1'b1), .V_LINES(VL), .V_EDGE(VE), .EN_LAG(EL),
    .SKIP_PERIOD(SP), .SKIP_PHASE(SPH)) i_delta_panel_timing (
    .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .frame_sync(frame_sync),
    .dir_ltr(dir_ltr), .pal_mode(pal_mode), .h_start(h_start), .h_clk_a(h_clk_a),
    .h_clk_b(h_clk_b), .v_start(v_start), .v_clk_a(v_clk_a), .v_clk_b(v_clk_b),
    .gate_en(gate_en), .clr_pulse(clr_pulse), .scan_ltr(scan_ltr),
    .vid_invert(vid_invert));

  delta_panel_timing #(.HALF(HALF), .H_PULSES(NP), .H_LEAD(LEAD), .CLR_W(CW),
    .CLR_GAP(CG), .USE_CLR(1'b0), .V_LINES(VL), .V_EDGE(VE), .EN_LAG(EL),
    .SKIP_PERIOD(SP), .SKIP_PHASE(SPH)) i_delta_panel_timing_noclr (
    .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .frame_sync(frame_sync),
    .dir_ltr(dir_ltr), .pal_mode(pal_mode), .h_start(n_hs), .h_clk_a(n_ha),
    .h_clk_b(n_hb), .v_start(n_vs), .v_clk_a(n_va), .v_clk_b(n_vb),
    .gate_en(n_en), .clr_pulse(n_clr), .scan_ltr(n_dir), .vid_invert(n_inv));

  task automatic chk(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // expected values for dot position p of line index v (frame-relative) with parity odd
  task automatic check_pos(input int p, input int v, input bit odd, input bit pal);
    int s, bs, e, ee;
    bit hs, in_b, ha, cl, act, eact, va, vb, en;
    s    = LEAD + (odd ? HALF : 0);
    hs   = (p >= s) && (p < s + 2*HALF);
    bs   = s + HALF;
    in_b = (p >= bs) && (p < bs + 2*HALF*NP);
    ha   = in_b && (((p - bs) / HALF) % 2 == 0);
    cl   = (p >= s - CG - CW) && (p < s - CG);
    e    = (p >= VE) ? v : v - 1;
    act  = (e >= 0) && (e < VL);
    vb   = act && (e % 2 == 0);
    va   = act && (e % 2 == 1);
    ee   = (p >= VE + EL) ? v : v - 1;
    eact = (ee >= 0) && (ee < VL);
    en   = !(pal && eact && (ee % SP == SPH));
    chk(h_start, hs, odd ? "R4 h_start odd-line shift" : "R2 h_start");
    chk(h_clk_a, ha, "R3 h_clk_a");
    chk(h_clk_b, in_b && !ha, "R3 h_clk_b");
    chk(clr_pulse, cl, "R5 clr_pulse");
    chk(n_clr, 1'b0, "R5 clr unused held low");
    chk(v_start, v == 0, "R6 v_start");
    chk(v_clk_a, va, "R7 v_clk_a");
    chk(v_clk_b, vb, "R7 v_clk_b");
    chk(gate_en, en, "R8 gate_en");
    chk(vid_invert, odd, "R9 vid_invert");
    chk(scan_ltr, dir_ltr, "R10 scan_ltr");
  endtask

  int gline = 0;

  task automatic run_frame(input bit pal, input bit dir);
    pal_mode = pal;
    dir_ltr  = dir;
    for (int v = 0; v < VL + 3; v++) begin
      line_sync  = 1'b1;
      frame_sync = (v == 0);
      @(negedge clk);
      line_sync  = 1'b0;
      frame_sync = 1'b0;
      gline++;
      for (int p = 0; p < LINE_LEN - 1; p++) begin
        @(negedge clk);
        check_pos(p, v, gline % 2 == 1, pal);
        if (v == 5 && p == 20) dir_ltr = ~dir_ltr;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    pal_mode = 1'b1;
    dir_ltr  = 1'b0;
    repeat (3) @(negedge clk);
    // R1: quiescent state under reset
    chk(h_start, 1'b0, "R1 h_start");
    chk(h_clk_a, 1'b0, "R1 h_clk_a");
    chk(h_clk_b, 1'b0, "R1 h_clk_b");
    chk(v_start, 1'b0, "R1 v_start");
    chk(v_clk_a, 1'b0, "R1 v_clk_a");
    chk(v_clk_b, 1'b0, "R1 v_clk_b");
    chk(gate_en, 1'b1, "R1 gate_en");
    chk(clr_pulse, 1'b0, "R1 clr_pulse");
    chk(scan_ltr, 1'b1, "R1 scan_ltr");
    chk(vid_invert, 1'b0, "R1 vid_invert");
    rst_n = 1'b1;
    @(negedge clk);
    run_frame(1'b0, 1'b1);
    run_frame(1'b1, 1'b0);
    run_frame(1'b1, 1'b1);
    run_frame(1'b0, 1'b0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule